// File: doc/BRIEF.md
# Floating-Point Reciprocal Exponent Unit

The unit takes one IEEE-754 operand per cycle, in single or double precision, and returns a coarse reciprocal estimate that has an exponent and no fraction. For an ordinary operand the result keeps the operand's sign and clears every fraction bit. Its exponent is the bitwise complement of the operand's exponent. An operand whose exponent field is zero (a zero or a subnormal) is the one exception: it gets the largest finite exponent instead. The estimate is meant to seed scaling steps in iterative divide and square-root sequences, where only the magnitude of the exponent matters.

NaN operands are handled separately. A signalling NaN is returned quieted and raises the invalid flag. A quiet NaN passes through unchanged. When default-NaN mode is enabled, every NaN is replaced by the canonical default NaN. The result and the flag are registered, so they appear one cycle after the operand is presented with its valid strobe.

Top module: `frecpx_unit`

## Requirements
- R1: `valid_o` is high exactly one cycle after a cycle in which `valid_i` was high. Reset clears `valid_o`, `res_o` and `invalid_o`.
- R2: For a non-NaN operand, the result sign equals the operand sign, and every fraction bit of the result is zero.
- R3: If a non-NaN operand has an all-zero exponent field, the result exponent is 8'hFE in single precision and 11'h7FE in double precision.
- R4: Any other non-NaN operand gets a result exponent equal to the bitwise NOT of its exponent field, so an infinity gives exponent zero.
- R5: A NaN has an all-ones exponent and a nonzero fraction. It is signalling when the top fraction bit is 0. With `dnan_i`=0, a signalling NaN returns the operand with the top fraction bit set, keeping sign and payload, and `invalid_o` is 1.
- R6: With `dnan_i`=0, a quiet NaN (top fraction bit 1) returns unchanged and `invalid_o` is 0.
- R7: With `dnan_i`=1, every NaN returns 32'h7FC00000 in single precision or 64'h7FF8000000000000 in double precision. `invalid_o` is still 1 for a signalling NaN.
- R8: `dbl_i`=1 selects double precision. With `dbl_i`=0, only `op_i[31:0]` is used, the result occupies `res_o[31:0]` and `res_o[63:32]` is zero.
- R9: `invalid_o` is never high while `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| op_i | input | 64 | Operand; single precision uses bits 31:0 |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision |
| dnan_i | input | 1 | Default-NaN mode enable |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| res_o | output | 64 | Reciprocal exponent result |
| invalid_o | output | 1 | Invalid-operation flag for a signalling NaN |

## Verification
The assertions check on every cycle:
- the one-cycle valid timing and that the flag is held low when idle;
- sign retention and cleared fraction for non-NaN operands, in both precisions;
- the zero-exponent substitution in double precision;
- that the invalid flag matches a signalling operand;
- the default-NaN pattern in double precision;
- the cleared upper word in single precision.

Only the bench's scenarios show the complemented exponent over a range of exponents, including the infinity-to-zero case. The same holds for payload retention when a signalling NaN is quieted, for the pass-through of quiet NaNs, and for garbage in the upper operand word being ignored in single precision.

// File: rtl/frecpx_pkg.sv
package frecpx_pkg;
  localparam int DATA_W    = 64;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
  localparam int NUM_FMT   = 2;

  typedef struct packed {
    logic [DATA_W-1:0] val;
    logic              invalid;
  } lane_res_t;
endpackage

// File: rtl/frecpx_lane.sv
module frecpx_lane
  import frecpx_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_i,
  input  logic         dnan_i,
  output lane_res_t    res_o
);
  localparam logic [FRAC_W-1:0] QBIT    = {1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [EXP_W-1:0]  MAX_FIN = {{(EXP_W-1){1'b1}}, 1'b0};

  logic              sgn;
  logic [EXP_W-1:0]  expn;
  logic [FRAC_W-1:0] frac;
  logic              is_nan, is_snan;
  logic [W-1:0]      r;

  assign {sgn, expn, frac} = op_i;
  assign is_nan  = (&expn) & (|frac);
  assign is_snan = is_nan & ~frac[FRAC_W-1];

  always_comb begin
    if (is_nan) begin
      r = dnan_i ? {1'b0, {EXP_W{1'b1}}, QBIT} : {sgn, expn, frac | QBIT};
    end else begin
      r = {sgn, (expn == '0) ? MAX_FIN : ~expn, {FRAC_W{1'b0}}};
    end
    res_o.val        = '0;
    res_o.val[W-1:0] = r;
    res_o.invalid    = is_snan;
  end
endmodule

// File: rtl/frecpx_unit.sv
module frecpx_unit
  import frecpx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] op_i,
  input  logic              dbl_i,
  input  logic              dnan_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic              invalid_o
);
  lane_res_t lane_res [NUM_FMT];
  lane_res_t sel;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
    localparam int EW = (g == 0) ? SP_EXP_W : DP_EXP_W;
    localparam int FW = (g == 0) ? SP_FRAC_W : DP_FRAC_W;
    localparam int LW = 1 + EW + FW;
    frecpx_lane #(.EXP_W(EW), .FRAC_W(FW)) u_lane (
      .op_i  (op_i[LW-1:0]),
      .dnan_i(dnan_i),
      .res_o (lane_res[g])
    );
  end

  assign sel = lane_res[dbl_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      res_o     <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o     <= sel.val;
        invalid_o <= sel.invalid;
      end else begin
        invalid_o <= 1'b0;
      end
    end
  end

  // operand classification seen from the ports, for the checks below
  logic op_nan, op_snan;
  always_comb begin
    if (dbl_i) begin
      op_nan  = (&op_i[62:52]) & (|op_i[51:0]);
      op_snan = op_nan & ~op_i[51];
    end else begin
      op_nan  = (&op_i[30:23]) & (|op_i[22:0]);
      op_snan = op_nan & ~op_i[22];
    end
  end

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));

  p_dp_sign_frac_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(dbl_i) && !$past(op_nan)) |->
      (res_o[51:0] == '0 && res_o[63] == $past(op_i[63])));

  p_sp_sign_frac_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(dbl_i) && !$past(op_nan)) |->
      (res_o[22:0] == '0 && res_o[31] == $past(op_i[31])));

  p_dp_zero_exp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(dbl_i) && $past(op_i[62:52]) == '0) |->
      (res_o[62:52] == 11'h7FE));

  p_invalid_snan_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (invalid_o == $past(op_snan)));

  p_dp_default_nan_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(dbl_i) && $past(dnan_i) && $past(op_nan)) |->
      (res_o == 64'h7FF8000000000000));

  p_sp_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(dbl_i)) |-> (res_o[63:32] == '0));

  p_idle_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !invalid_o);
endmodule

// File: tb/tb_frecpx_unit.sv
module tb_frecpx_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] op_i = '0;
  logic        dbl_i = 1'b0;
  logic        dnan_i = 1'b0;
  logic        valid_o;
  logic [63:0] res_o;
  logic        invalid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic        inv;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  frecpx_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .dbl_i(dbl_i), .dnan_i(dnan_i), .valid_o(valid_o), .res_o(res_o),
    .invalid_o(invalid_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // model written from the requirements
  function automatic void model(input logic [63:0] op, input bit dbl, input bit dn,
                                output logic [63:0] r, output logic inv);
    logic s;
    logic [10:0] e;
    logic [51:0] f;
    bit nan, snan;
    if (dbl) begin
      s = op[63]; e = op[62:52]; f = op[51:0];
      nan = (e == 11'h7FF) && (f != 0);
      snan = nan && !f[51];
      if (nan) r = dn ? 64'h7FF8000000000000 : (op | 64'h0008000000000000);
      else r = {s, (e == 0) ? 11'h7FE : ~e, 52'd0};
    end else begin
      s = op[31]; e = {3'd0, op[30:23]}; f = {29'd0, op[22:0]};
      nan = (e[7:0] == 8'hFF) && (f != 0);
      snan = nan && !f[22];
      if (nan) r = dn ? 64'h7FC00000 : {32'd0, op[31:0] | 32'h00400000};
      else r = {32'd0, s, (e[7:0] == 0) ? 8'hFE : ~e[7:0], 23'd0};
    end
    inv = snan;
  endfunction

  task automatic drive(input logic [63:0] op, input bit dbl, input bit dn,
                       input string tag);
    exp_t x;
    model(op, dbl, dn, x.res, x.inv);
    x.tag = tag;
    sb.push_back(x);
    valid_i = 1'b1; op_i = op; dbl_i = dbl; dnan_i = dn;
    @(negedge clk_i);
    valid_i = 1'b0; op_i = $urandom; dbl_i = $urandom; dnan_i = $urandom;
  endtask

  // monitor: compares each result against the scoreboard head
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (valid_o) begin
          if (sb.size() == 0) begin
            check(1'b0, "R1 unexpected valid_o", {63'd0, valid_o}, 64'd0);
          end else begin
            exp_t x;
            x = sb.pop_front();
            check(res_o == x.res, x.tag, res_o, x.res);
            check(invalid_o == x.inv, {x.tag, " invalid"}, {63'd0, invalid_o}, {63'd0, x.inv});
          end
        end else begin
          check(!invalid_o, "R9 flag while idle", {63'd0, invalid_o}, 64'd0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(valid_o == 0 && invalid_o == 0 && res_o == 0, "R1 reset state", res_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // single precision
    drive(64'h3F800000, 0, 0, "R4 sp 1.0");
    drive(64'hC0200000, 0, 0, "R2 sp negative");
    drive(64'h00000000, 0, 0, "R3 sp zero");
    drive(64'h80000001, 0, 0, "R3 sp neg subnormal");
    drive(64'h7F800000, 0, 0, "R4 sp infinity");
    drive(64'h7F800001, 0, 0, "R5 sp snan");
    drive(64'hFFA5A5A5, 0, 0, "R5 sp snan payload");
    drive(64'hFFC01234, 0, 0, "R6 sp qnan");
    drive(64'h7F800001, 0, 1, "R7 sp default snan");
    drive(64'hFFC01234, 0, 1, "R7 sp default qnan");
    drive(64'hDEADBEEF3F800000, 0, 0, "R8 sp upper ignored");
    drive(64'hFFFFFFFF7F800001, 0, 0, "R8 sp upper ignored nan");
    @(negedge clk_i);
    // double precision, including back-to-back and gaps
    drive(64'h3FF0000000000000, 1, 0, "R4 dp 1.0");
    drive(64'h0000000000000000, 1, 0, "R3 dp zero");
    drive(64'h8000000000000001, 1, 0, "R3 dp neg subnormal");
    drive(64'h7FEFFFFFFFFFFFFF, 1, 0, "R4 dp max finite");
    drive(64'hFFF0000000000000, 1, 0, "R4 dp neg infinity");
    drive(64'hC00123456789ABCD, 1, 0, "R2 dp fraction cleared");
    drive(64'h7FF0000000000001, 1, 0, "R5 dp snan");
    drive(64'hFFF7000000000ABC, 1, 0, "R5 dp snan payload");
    drive(64'h7FF8000000000ABC, 1, 0, "R6 dp qnan");
    drive(64'hFFF0000000000001, 1, 1, "R7 dp default snan");
    drive(64'h7FF8000000000ABC, 1, 1, "R7 dp default qnan");
    drive(64'h3FF0000000000000, 1, 1, "R7 dp dnan no effect on number");
    for (int i = 0; i < 200; i++) begin
      drive({$urandom, $urandom}, 1'($urandom), 1'($urandom), "R4 random");
      if (i % 7 == 0) @(negedge clk_i);
    end
    repeat (3) @(negedge clk_i);
    check(sb.size() == 0, "R1 all results returned", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule